// File: doc/BRIEF.md
# Staged-commit wide software register

This block is a software-writable register that is wider than the CPU data path. Software reaches it one sub-word at a time. Each sub-word write lands in a staging buffer with its data and per-bit enables, and a pending flag is set. Nothing reaches the visible field bits until a commit trigger fires. At that point every staged bit whose enable is set is applied in one cycle, so a field that straddles two sub-words never shows a half-updated value.

The commit trigger is chosen by a parameter. It can be an external active-high or active-low signal, or the register itself. In the self-triggered case a write to the highest-numbered sub-word is registered for one cycle and then used as the trigger. A parameter selects how the field bits react to staged data: plain replacement, write-one-to-set or write-one-to-clear. Bit order can be LSB-first or MSB-first. Another parameter makes any read access clear the fields. A software-modified pulse marks every cycle in which the field bits are updated.

Top module: `wbuf_wide_reg`

## Requirements
- R1: After reset `field_q` equals `RST_VAL`, `swmod` is low, and the staging buffer is empty (pending, data, enables and the delayed self-trigger all zero).
- R2: A write access (`req_is_wr`=1) with `req_strb[i]`=1 sets pending and stores `wr_data`/`wr_biten` into slice i of the staging buffer. In LSB-first order slice i is bits [ACC_W*(i+1)-1 : ACC_W*i]. Other slices keep their contents, and `field_q` does not change until a commit.
- R3: With `MSB0`=1, slice i is bits [REG_W-ACC_W*i-1 : REG_W-ACC_W*(i+1)], and the stored word is bit-reversed (bit b of the bus goes to bit ACC_W-1-b of the slice).
- R4: With `TSEL`=TS_SELF, a write to sub-word NSUB-1 raises the commit trigger in the following cycle. `ext_trig` is ignored.
- R5: With TS_EXT_HI the trigger is `ext_trig`. With TS_EXT_LO the trigger is the inverse of `ext_trig`.
- R6: A commit (pending AND trigger) updates only the bits whose staged enable is 1. All other field bits hold.
- R7: In any cycle where the trigger is active, the staging buffer is cleared (pending, data, enables). This clear wins over a sub-word write in the same cycle, so that write is lost.
- R8: `MODE`=WM_PLAIN loads the staged data bit. WM_SET sets bits where staged data and enable are both 1. WM_CLR clears those bits.
- R9: `swmod` is high in exactly the cycles whose clock edge updates the fields by commit or by read-clear. With `READ_CLR`=1, a read access (`req_is_wr`=0 with any strobe) clears `field_q` to zero, unless a commit happens in the same cycle, in which case the commit wins.
- R10: A trigger with nothing pending leaves `field_q` unchanged and `swmod` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_strb | input | NSUB | Decoded access strobe, one per sub-word |
| req_is_wr | input | 1 | 1 = write access, 0 = read access |
| wr_data | input | ACC_W | Write data of the access |
| wr_biten | input | ACC_W | Per-bit write enables of the access |
| ext_trig | input | 1 | External commit trigger (polarity set by TSEL) |
| field_q | output | REG_W | Committed field values |
| swmod | output | 1 | Software-modified pulse |

## Verification
The bench checks that a lower-half write alone leaves the fields untouched. A design that committed each sub-word directly would expose a torn value here. It puts a write in the same cycle as the self-trigger commit; a design giving the write priority would let stale data leak into the next commit. The MSB-first instance checks slice placement and bit reversal, since swapped halves or unreversed words show up as wrong bit positions. The read-clear instance gets a read in the commit cycle, where the wrong priority would zero the freshly committed bits.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef enum logic [1:0] {
    WM_PLAIN = 2'd0,
    WM_SET   = 2'd1,
    WM_CLR   = 2'd2
  } wmode_e;

  typedef enum logic [1:0] {
    TS_EXT_HI = 2'd0,
    TS_EXT_LO = 2'd1,
    TS_SELF   = 2'd2
  } tsel_e;

  // Lowest bit index of staging slice idx
  function automatic int slot_base(input int idx, input int reg_w, input int acc_w, input bit msb0);
    if (msb0) return reg_w - acc_w * (idx + 1);
    return acc_w * idx;
  endfunction

  // Next value of one field bit under a commit
  function automatic logic field_bit(input wmode_e m, input logic cur, input logic d, input logic en);
    case (m)
      WM_SET:  return cur | (d & en);
      WM_CLR:  return cur & ~(d & en);
      default: return en ? d : cur;
    endcase
  endfunction

endpackage

// File: rtl/wbuf_stage.sv
module wbuf_stage #(
  parameter int REG_W = 64,
  parameter int ACC_W = 32,
  parameter bit MSB0  = 1'b0,
  localparam int NSUB = REG_W / ACC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSUB-1:0]  wr_hit,
  input  logic [ACC_W-1:0] wdata,
  input  logic [ACC_W-1:0] wbiten,
  input  logic             clear,
  output logic [REG_W-1:0] stg_data,
  output logic [REG_W-1:0] stg_biten,
  output logic             stg_pending
);
  logic [ACC_W-1:0] d_ord, e_ord;
  logic [REG_W-1:0] nd, ne;
  logic             np;

  always_comb begin
    for (int b = 0; b < ACC_W; b++) begin
      d_ord[b] = MSB0 ? wdata[ACC_W-1-b]  : wdata[b];
      e_ord[b] = MSB0 ? wbiten[ACC_W-1-b] : wbiten[b];
    end
  end

  always_comb begin
    nd = stg_data;
    ne = stg_biten;
    np = stg_pending;
    for (int i = 0; i < NSUB; i++) begin
      if (wr_hit[i]) begin
        nd[wbuf_pkg::slot_base(i, REG_W, ACC_W, MSB0) +: ACC_W] = d_ord;
        ne[wbuf_pkg::slot_base(i, REG_W, ACC_W, MSB0) +: ACC_W] = e_ord;
        np = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      stg_data    <= '0;
      stg_biten   <= '0;
      stg_pending <= 1'b0;
    end else begin
      stg_data    <= nd;
      stg_biten   <= ne;
      stg_pending <= np;
    end
  end
endmodule

// File: rtl/wbuf_trig.sv
module wbuf_trig #(
  parameter wbuf_pkg::tsel_e TSEL = wbuf_pkg::TS_EXT_HI
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_trig,
  input  logic self_raw,
  output logic trig_eff
);
  logic trig_q;

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= self_raw;
  end

  always_comb begin
    case (TSEL)
      wbuf_pkg::TS_SELF:   trig_eff = trig_q;
      wbuf_pkg::TS_EXT_LO: trig_eff = ~ext_trig;
      default:             trig_eff = ext_trig;
    endcase
  end
endmodule

// File: rtl/wbuf_field.sv
module wbuf_field #(
  parameter int              REG_W    = 64,
  parameter wbuf_pkg::wmode_e MODE    = wbuf_pkg::WM_PLAIN,
  parameter logic [REG_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic             rd_clear,
  input  logic [REG_W-1:0] stg_data,
  input  logic [REG_W-1:0] stg_biten,
  output logic [REG_W-1:0] field_q
);
  logic [REG_W-1:0] f_next;

  always_comb begin
    for (int b = 0; b < REG_W; b++)
      f_next[b] = wbuf_pkg::field_bit(MODE, field_q[b], stg_data[b], stg_biten[b]);
  end

  always_ff @(posedge clk) begin
    if (rst)           field_q <= RST_VAL;
    else if (commit)   field_q <= f_next;
    else if (rd_clear) field_q <= '0;
  end
endmodule

// File: rtl/wbuf_wide_reg.sv
module wbuf_wide_reg #(
  parameter int               REG_W    = 64,
  parameter int               ACC_W    = 32,
  parameter wbuf_pkg::tsel_e  TSEL     = wbuf_pkg::TS_SELF,
  parameter wbuf_pkg::wmode_e MODE     = wbuf_pkg::WM_PLAIN,
  parameter bit               MSB0     = 1'b0,
  parameter bit               READ_CLR = 1'b0,
  parameter logic [REG_W-1:0] RST_VAL  = '0,
  localparam int NSUB = REG_W / ACC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSUB-1:0]  req_strb,
  input  logic             req_is_wr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic [ACC_W-1:0] wr_biten,
  input  logic             ext_trig,
  output logic [REG_W-1:0] field_q,
  output logic             swmod
);
  logic [NSUB-1:0]  wr_hit;
  logic             rd_access, self_raw, trig_eff, commit_fire, rd_clear;
  logic [REG_W-1:0] stg_data, stg_biten;
  logic             stg_pending;

  assign wr_hit      = req_strb & {NSUB{req_is_wr}};
  assign rd_access   = (|req_strb) & ~req_is_wr;
  assign self_raw    = req_strb[NSUB-1] & req_is_wr;
  assign commit_fire = stg_pending & trig_eff;
  assign rd_clear    = READ_CLR & rd_access;
  assign swmod       = commit_fire | rd_clear;

  wbuf_stage #(.REG_W(REG_W), .ACC_W(ACC_W), .MSB0(MSB0)) u_stage (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .wdata(wr_data), .wbiten(wr_biten),
    .clear(trig_eff), .stg_data(stg_data), .stg_biten(stg_biten), .stg_pending(stg_pending)
  );

  wbuf_trig #(.TSEL(TSEL)) u_trig (
    .clk(clk), .rst(rst), .ext_trig(ext_trig), .self_raw(self_raw), .trig_eff(trig_eff)
  );

  wbuf_field #(.REG_W(REG_W), .MODE(MODE), .RST_VAL(RST_VAL)) u_field (
    .clk(clk), .rst(rst), .commit(commit_fire), .rd_clear(rd_clear),
    .stg_data(stg_data), .stg_biten(stg_biten), .field_q(field_q)
  );
endmodule

// File: rtl/wbuf_wide_reg_chk.sv
module wbuf_wide_reg_chk #(
  parameter int REG_W     = 64,
  parameter int NSUB      = 2,
  parameter bit SELF_TRIG = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [NSUB-1:0]  req_strb,
  input logic             req_is_wr,
  input logic             trig_eff,
  input logic             stg_pending,
  input logic [REG_W-1:0] stg_biten,
  input logic [REG_W-1:0] field_q,
  input logic             swmod
);
  // R7
  stage_clear_chk: assert property (@(posedge clk) disable iff (rst)
    trig_eff |=> (!stg_pending && stg_biten == '0));

  // R2
  pending_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((|req_strb) && req_is_wr && !trig_eff) |=> stg_pending);

  // R9
  field_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !swmod |=> $stable(field_q));

  // R10
  idle_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_eff && !stg_pending) |-> !$isunknown(field_q));

  generate
    if (SELF_TRIG) begin : g_self
      // R4
      self_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (req_strb[NSUB-1] && req_is_wr) |=> trig_eff);
    end
  endgenerate
endmodule

bind wbuf_wide_reg wbuf_wide_reg_chk #(
  .REG_W(REG_W), .NSUB(NSUB), .SELF_TRIG(TSEL == wbuf_pkg::TS_SELF)
) u_chk (
  .clk(clk), .rst(rst), .req_strb(req_strb), .req_is_wr(req_is_wr),
  .trig_eff(trig_eff), .stg_pending(stg_pending), .stg_biten(stg_biten),
  .field_q(field_q), .swmod(swmod)
);

// File: tb/wbuf_wide_reg_bench.sv
`timescale 1ns/1ps
module wbuf_wide_reg_bench;
  import wbuf_pkg::*;
  localparam int RW = 64, AW = 32, NS = 2;
  localparam logic [RW-1:0] RST0 = 64'h0123_4567_89AB_CDEF;
  localparam logic [RW-1:0] RST1 = '1;
  localparam logic [RW-1:0] RST2 = '0;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NS-1:0] strb = '0;
  logic is_wr = 1'b0;
  logic [AW-1:0] wd = '0, wb = '0;
  logic ta = 1'b0, tb = 1'b1, tc = 1'b0;
  logic [RW-1:0] fq0, fq1, fq2;
  logic sm0, sm1, sm2;

  // instance 0: self trigger, plain, LSB-first
  wbuf_wide_reg #(.TSEL(TS_SELF), .MODE(WM_PLAIN), .MSB0(1'b0), .READ_CLR(1'b0), .RST_VAL(RST0))
    u_wbuf_wide_reg (.clk(clk), .rst(rst), .req_strb(strb), .req_is_wr(is_wr), .wr_data(wd),
                     .wr_biten(wb), .ext_trig(ta), .field_q(fq0), .swmod(sm0));
  // instance 1: active-low external, write-one-to-clear, MSB-first
  wbuf_wide_reg #(.TSEL(TS_EXT_LO), .MODE(WM_CLR), .MSB0(1'b1), .READ_CLR(1'b0), .RST_VAL(RST1))
    u_lo (.clk(clk), .rst(rst), .req_strb(strb), .req_is_wr(is_wr), .wr_data(wd),
          .wr_biten(wb), .ext_trig(tb), .field_q(fq1), .swmod(sm1));
  // instance 2: active-high external, write-one-to-set, read clears
  wbuf_wide_reg #(.TSEL(TS_EXT_HI), .MODE(WM_SET), .MSB0(1'b0), .READ_CLR(1'b1), .RST_VAL(RST2))
    u_hi (.clk(clk), .rst(rst), .req_strb(strb), .req_is_wr(is_wr), .wr_data(wd),
          .wr_biten(wb), .ext_trig(tc), .field_q(fq2), .swmod(sm2));

  logic [RW-1:0] m_f[3], m_d[3], m_e[3];
  logic m_p[3], m_tq[3];
  int n_chk = 0, n_fail = 0;

  function automatic logic [AW-1:0] rev32(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int b = 0; b < AW; b++) r[AW-1-b] = v[b];
    return r;
  endfunction

  function automatic logic trig_of(input int k, input logic a, input logic b, input logic c);
    if (k == 0) return m_tq[0];
    if (k == 1) return ~b;
    return c;
  endfunction

  function automatic logic [RW-1:0] apply(input int k, input logic [RW-1:0] f, d, e);
    if (k == 0) return (f & ~e) | (d & e);
    if (k == 1) return f & ~(d & e);
    return f | (d & e);
  endfunction

  task automatic check(input string tag, input string what, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [NS-1:0] s, input logic w, input logic [AW-1:0] d, input logic [AW-1:0] b,
                      input logic a, input logic bt, input logic c, input string tag);
    logic cm[3];
    logic rd;
    logic [RW-1:0] sms;
    @(negedge clk);
    strb = s; is_wr = w; wd = d; wb = b; ta = a; tb = bt; tc = c;
    #1;
    rd = (|s) & ~w;
    for (int k = 0; k < 3; k++) cm[k] = m_p[k] & trig_of(k, a, bt, c);
    sms = {61'd0, sm2, sm1, sm0};
    check(tag, "swmod", sms, {61'd0, cm[2] | rd, cm[1], cm[0]});
    for (int k = 0; k < 3; k++) begin
      if (cm[k]) m_f[k] = apply(k, m_f[k], m_d[k], m_e[k]);
      else if (k == 2 && rd) m_f[k] = '0;
      if (trig_of(k, a, bt, c)) begin
        m_p[k] = 1'b0; m_d[k] = '0; m_e[k] = '0;
      end else begin
        for (int i = 0; i < NS; i++) begin
          if (s[i] && w) begin
            int lo;
            lo = (k == 1) ? (NS - 1 - i) * AW : i * AW;
            m_d[k][lo +: AW] = (k == 1) ? rev32(d) : d;
            m_e[k][lo +: AW] = (k == 1) ? rev32(b) : b;
            m_p[k] = 1'b1;
          end
        end
      end
    end
    m_tq[0] = s[NS-1] & w;
    @(posedge clk);
    #1;
    check(tag, "field0", fq0, m_f[0]);
    check(tag, "field1", fq1, m_f[1]);
    check(tag, "field2", fq2, m_f[2]);
  endtask

  task automatic idle(input logic a, input logic bt, input logic c, input string tag);
    step('0, 1'b0, '0, '0, a, bt, c, tag);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_f[0] = RST0; m_f[1] = RST1; m_f[2] = RST2;
    for (int k = 0; k < 3; k++) begin
      m_d[k] = '0; m_e[k] = '0; m_p[k] = 1'b0; m_tq[k] = 1'b0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    check("R1", "field0", fq0, RST0);
    check("R1", "field1", fq1, RST1);
    check("R1", "field2", fq2, RST2);
    check("R1", "swmod", {61'd0, sm2, sm1, sm0}, '0);
    // R1 empty buffer: trigger right after reset changes nothing
    idle(1'b1, 1'b0, 1'b1, "R1");
    // R2 lower sub-word only: no field change
    step(2'b01, 1'b1, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, "R2");
    idle(1'b0, 1'b1, 1'b0, "R2");
    idle(1'b1, 1'b1, 1'b0, "R2");
    // R4 upper write triggers self commit one cycle later
    step(2'b10, 1'b1, 32'h1234_5678, 32'hFFFF_0000, 1'b0, 1'b1, 1'b0, "R4");
    idle(1'b0, 1'b1, 1'b0, "R4");
    // R5 polarity of external triggers
    idle(1'b0, 1'b0, 1'b0, "R5");
    idle(1'b0, 1'b1, 1'b1, "R5");
    // R10 triggers with nothing pending
    idle(1'b1, 1'b0, 1'b1, "R10");
    // R3 MSB-first slice and reversal
    step(2'b01, 1'b1, 32'h0000_00F1, 32'h0000_0FFF, 1'b0, 1'b1, 1'b0, "R3");
    idle(1'b0, 1'b0, 1'b0, "R3");
    step(2'b10, 1'b1, 32'h8000_0001, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, "R3");
    idle(1'b0, 1'b0, 1'b0, "R3");
    // R7 write in commit cycle is lost
    step(2'b10, 1'b1, 32'hCAFE_F00D, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, "R7");
    step(2'b01, 1'b1, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, "R7");
    step(2'b10, 1'b1, 32'h0000_0005, 32'h0000_00FF, 1'b0, 1'b1, 1'b0, "R7");
    idle(1'b0, 1'b1, 1'b0, "R7");
    // R8 / R6 set, clear and plain with partial enables
    step(2'b11, 1'b1, 32'hF0F0_F0F0, 32'hFFFF_0000, 1'b0, 1'b1, 1'b0, "R8");
    idle(1'b0, 1'b0, 1'b1, "R8");
    step(2'b01, 1'b1, 32'h0F0F_0F0F, 32'h00FF_00FF, 1'b0, 1'b1, 1'b0, "R6");
    idle(1'b0, 1'b0, 1'b1, "R6");
    // R9 read clears, then commit wins over same-cycle read
    step(2'b01, 1'b0, '0, '0, 1'b0, 1'b1, 1'b0, "R9");
    step(2'b01, 1'b1, 32'h0000_000F, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, "R9");
    step(2'b01, 1'b0, '0, '0, 1'b0, 1'b1, 1'b1, "R9");
    idle(1'b0, 1'b1, 1'b0, "R9");
    // R6 random traffic
    for (int n = 0; n < 400; n++) begin
      step(NS'($urandom), 1'($urandom), $urandom, $urandom,
           1'($urandom), ($urandom % 4) != 0, ($urandom % 4) == 0, "R6");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule